// File: doc/BRIEF.md
# Dual Edge-Selectable Input Capture

This block gives a timer two capture channels. Each channel watches one external pin. When the pin shows the edge chosen for that channel, the channel copies the free-running counter value into its own capture register and raises its status flag. Software picks the trigger for each channel with a 2-bit code: off, rising, falling or both edges. The codes for the two channels are packed side by side in one mode field.

Each pin is synchronized to the block clock by two flip-flops. Edges are found by comparing the synchronized level with its value one cycle earlier. The capture registers and a status word can be read through a simple word-addressed bus. A flag is cleared by writing a one to its bit in the status word. A flag only drives its channel's interrupt request when that channel's enable bit is set.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset, both capture registers read 0, both flags are 0 and both interrupt requests are 0.
- R2: Suppose a pin level is first sampled at clock edge k and it forms a qualifying edge. The capture register then takes the value `tmr_count` had at edge k+2, and the flag is 1 from that edge on. Before edge k+2 the register still holds its old value.
- R3: Mode code 0 disables the channel. Pin changes then leave its capture register and its flag unchanged.
- R4: Mode code 1 captures on a low-to-high pin change only. Mode code 2 captures on a high-to-low pin change only.
- R5: Mode code 3 captures on both pin changes.
- R6: The mode code of channel n is `mode_field[2n+1:2n]`. Bits that belong to the other channel have no effect on channel n.
- R7: Each channel has its own capture register. A capture on one channel leaves the other channel's register and flag unchanged.
- R8: Bus reads are combinational from `bus_addr`:
  - word 0 returns channel 0's capture register.
  - word 1 returns channel 1's capture register.
  - word 2 returns the status word, with bit n equal to the flag of channel n and all other bits 0.
  - any other word returns 0.
- R9: A write to word 2 clears the flag of channel n when `bus_wdata[n]` is 1. A flag whose write bit is 0 stays as it was.
- R10: A qualifying edge while the flag is already set overwrites the capture register, and the flag stays 1.
- R11: If a flag clear and a capture on the same channel take effect at the same clock edge, the flag ends up 1.
- R12: `cap_irq[n]` is 1 exactly when the flag of channel n is 1 and `irq_en[n]` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_count | input | 32 | Running counter value to capture |
| pin_in | input | 2 | Raw capture pins, bit n for channel n |
| mode_field | input | 4 | Packed 2-bit trigger codes, channel n at bits 2n+1:2n |
| irq_en | input | 2 | Interrupt enable per channel |
| bus_addr | input | 4 | Word address for reads and writes |
| bus_wr | input | 1 | Write strobe; acts only at the status word |
| bus_wdata | input | 2 | Write-one-to-clear mask for the flags |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| cap_val | output | 64 | Capture registers, channel n at bits 32n+31:32n |
| cap_flag | output | 2 | Capture flag per channel |
| cap_irq | output | 2 | Interrupt request per channel |

## Verification
A wrong synchronizer or edge-history state shows up in two ways: a capture is missed, or an extra capture appears. Either one changes `cap_val` or leaves it alone at the third clock edge after the pin moves, so comparing every register change against a predicted counter value catches it within one edge event. A flag that stays set, or clears too early, shows on `cap_flag` and on the status word one cycle after the write or capture that should have set it. The bench lines up clear writes against capture edges in the same cycle so that the priority between them can be seen at the port.

// File: rtl/capt_pkg.sv
package capt_pkg;

  // Trigger selection code per channel
  typedef enum logic [1:0] {
    CAP_OFF  = 2'd0,
    CAP_RISE = 2'd1,
    CAP_FALL = 2'd2,
    CAP_BOTH = 2'd3
  } cap_mode_e;

  localparam int unsigned MODE_W = 2;

endpackage

// File: rtl/capt_sync.sv
module capt_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);

  logic meta_q, sync_q, prev_q;
  logic meta_d, sync_d, prev_d;

  // next state
  always_comb begin
    meta_d = pin;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;

endmodule

// File: rtl/capt_channel.sv
module capt_channel
  import capt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              fall,
  input  logic [MODE_W-1:0] mode,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              clr,
  output logic [CNT_W-1:0]  cap_q,
  output logic              flag_q
);

  cap_mode_e         mode_e;
  logic              trig;
  logic [CNT_W-1:0]  cap_d;
  logic              flag_d;
  logic              cap_en;

  assign mode_e = cap_mode_e'(mode);

  always_comb begin
    unique case (mode_e)
      CAP_RISE: trig = rise;
      CAP_FALL: trig = fall;
      CAP_BOTH: trig = rise | fall;
      default:  trig = 1'b0;
    endcase
  end

  // next state: capture has priority over clear
  assign cap_en = trig;
  always_comb begin
    cap_d  = cap_en ? cnt_in : cap_q;
    flag_d = flag_q;
    if (clr)    flag_d = 1'b0;
    if (cap_en) flag_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cap_q  <= cap_d;
      flag_q <= flag_d;
    end
  end

  AST_OFF_HOLDS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == CAP_OFF) |=> $stable(cap_q)); // R3
  AST_OFF_HOLDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == CAP_OFF && !clr) |=> $stable(flag_q)); // R3
  AST_RISE_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == CAP_RISE && rise) |=> (flag_q && cap_q == $past(cnt_in))); // R4
  AST_FALL_IGNORES_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == CAP_FALL && rise) |=> $stable(cap_q)); // R4
  AST_CLEAR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !rise && !fall) |=> !flag_q); // R9
  AST_CAPTURE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && mode_e == CAP_BOTH && (rise || fall)) |=> flag_q); // R11

endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import capt_pkg::*;
#(
  parameter int unsigned NUM_CH   = 2,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CAP_BASE = 0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [CNT_W-1:0]          tmr_count,
  input  logic [NUM_CH-1:0]         pin_in,
  input  logic [NUM_CH*MODE_W-1:0]  mode_field,
  input  logic [NUM_CH-1:0]         irq_en,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic [NUM_CH-1:0]         bus_wdata,
  output logic [CNT_W-1:0]          bus_rdata,
  output logic [NUM_CH*CNT_W-1:0]   cap_val,
  output logic [NUM_CH-1:0]         cap_flag,
  output logic [NUM_CH-1:0]         cap_irq
);

  localparam int unsigned STAT_ADDR = CAP_BASE + NUM_CH;

  logic [NUM_CH-1:0] rise, fall, clr;
  logic              stat_sel;

  assign stat_sel = (bus_addr == ADDR_W'(STAT_ADDR));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    capt_sync u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (pin_in[g]),
      .rise  (rise[g]),
      .fall  (fall[g])
    );

    assign clr[g] = bus_wr & stat_sel & bus_wdata[g];

    capt_channel #(.CNT_W(CNT_W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .rise   (rise[g]),
      .fall   (fall[g]),
      .mode   (mode_field[g*MODE_W +: MODE_W]),
      .cnt_in (tmr_count),
      .clr    (clr[g]),
      .cap_q  (cap_val[g*CNT_W +: CNT_W]),
      .flag_q (cap_flag[g])
    );
  end

  assign cap_irq = cap_flag & irq_en;

  // read mux
  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(CAP_BASE + i))
        bus_rdata = cap_val[i*CNT_W +: CNT_W];
    end
    if (stat_sel)
      bus_rdata[NUM_CH-1:0] = cap_flag;
  end

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((cap_irq & ~irq_en) == '0)); // R12
  AST_FLAG_RISE_MEANS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_flag[0]) |-> (cap_val[CNT_W-1:0] == $past(tmr_count))); // R2

endmodule

// File: tb/edge_capture_unit_bench.sv
`timescale 1ns/1ps
module edge_capture_unit_bench;

  localparam realtime TCK = 4.0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cnt;
  logic [1:0]  pin;
  logic [1:0]  bmode [2];
  logic [3:0]  mode_field;
  logic [1:0]  irq_en;
  logic [3:0]  bus_addr;
  logic        bus_wr;
  logic [1:0]  bus_wdata;
  logic [31:0] bus_rdata;
  logic [63:0] cap_val;
  logic [1:0]  cap_flag, cap_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit mon_on = 0;

  logic [31:0] exp_q0[$], exp_q1[$];
  string       req_q0[$], req_q1[$];
  logic [31:0] last_exp [2];

  assign mode_field = {bmode[1], bmode[0]};

  always #(TCK/2) clk = ~clk;

  edge_capture_unit u_edge_capture_unit (
    .clk(clk), .rst_n(rst_n), .tmr_count(cnt), .pin_in(pin),
    .mode_field(mode_field), .irq_en(irq_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_val(cap_val), .cap_flag(cap_flag), .cap_irq(cap_irq)
  );

  task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // free-running counter
  initial begin
    cnt = 32'h1000_0000;
    forever @(posedge clk) cnt <= cnt + 32'd1;
  end

  // monitor: every capture register change must match the scoreboard
  initial begin
    logic [31:0] prev [2];
    prev[0] = '0; prev[1] = '0;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        for (int ch = 0; ch < 2; ch++) begin
          logic [31:0] cur;
          cur = cap_val[ch*32 +: 32];
          if (cur !== prev[ch]) begin
            if ((ch == 0 ? exp_q0.size() : exp_q1.size()) == 0) begin
              n_chk++; n_fail++;
              $display("FAIL R3/R7 unexpected capture ch%0d actual=%h expected=none", ch, cur);
            end else if (ch == 0) begin
              check32(req_q0.pop_front(), cur, exp_q0.pop_front());
            end else begin
              check32(req_q1.pop_front(), cur, exp_q1.pop_front());
            end
            prev[ch] = cur;
          end
        end
      end
    end
  end

  // driver: move a pin, predict any capture
  task automatic drive_pin(int ch, logic val, string req);
    logic old, q;
    @(negedge clk);
    old = pin[ch];
    if (val != old) begin
      q = (bmode[ch] == 2'd1 && val) || (bmode[ch] == 2'd2 && !val) || (bmode[ch] == 2'd3);
      if (q) begin
        last_exp[ch] = cnt + 32'd2;
        if (ch == 0) begin exp_q0.push_back(cnt + 32'd2); req_q0.push_back(req); end
        else         begin exp_q1.push_back(cnt + 32'd2); req_q1.push_back(req); end
      end
    end
    pin[ch] = val;
    repeat (4) @(negedge clk);
  endtask

  task automatic drained(string req);
    n_chk++;
    if (exp_q0.size() != 0 || exp_q1.size() != 0) begin
      n_fail++;
      $display("FAIL %s missed capture actual=%0d/%0d pending expected=0", req, exp_q0.size(), exp_q1.size());
      exp_q0.delete(); exp_q1.delete(); req_q0.delete(); req_q1.delete();
    end
  endtask

  task automatic w1c(logic [1:0] mask);
    @(negedge clk);
    bus_addr = 4'd2; bus_wr = 1'b1; bus_wdata = mask;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #0.5 d = bus_rdata;
  endtask

  initial begin
    #(TCK * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    logic [31:0] d, hold;
    rst_n = 1'b0; pin = '0; bmode[0] = 2'd0; bmode[1] = 2'd0;
    irq_en = '0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    last_exp[0] = '0; last_exp[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check32("R1 cap_val lo", cap_val[31:0], '0);
    check32("R1 cap_val hi", cap_val[63:32], '0);
    check32("R1 flags", {30'd0, cap_flag}, '0);
    check32("R1 irq", {30'd0, cap_irq}, '0);
    mon_on = 1;

    // R3 disabled channel ignores both edges
    drive_pin(0, 1'b1, "R3"); drive_pin(0, 1'b0, "R3");
    check32("R3 flag stays clear", {31'd0, cap_flag[0]}, '0);
    drained("R3");

    // R2 latency and R4 rising capture
    bmode[0] = 2'd1;
    @(negedge clk);
    hold = cap_val[31:0];
    pin[0] = 1'b1;
    last_exp[0] = cnt + 32'd2;
    exp_q0.push_back(cnt + 32'd2); req_q0.push_back("R2 latency value");
    @(negedge clk); @(negedge clk);
    check32("R2 not yet captured", cap_val[31:0], hold);
    repeat (4) @(negedge clk);
    check32("R2 flag set", {31'd0, cap_flag[0]}, 32'd1);
    drive_pin(0, 1'b0, "R4 falling ignored in rise mode");
    drained("R4");

    // R12 interrupt gating
    check32("R12 irq masked", {31'd0, cap_irq[0]}, '0);
    irq_en = 2'b01;
    @(negedge clk);
    check32("R12 irq enabled", {31'd0, cap_irq[0]}, 32'd1);

    // R8 bus reads
    rd(4'd0, d); check32("R8 word0", d, last_exp[0]);
    rd(4'd2, d); check32("R8 status", d, 32'd1);
    rd(4'd3, d); check32("R8 unused word", d, '0);

    // R4 falling mode on channel 1, R6 field position, R7 independence
    bmode[1] = 2'd2;
    drive_pin(1, 1'b1, "R4 rising ignored in fall mode");
    drive_pin(1, 1'b0, "R4 falling capture");
    drained("R6");
    check32("R7 ch0 register untouched", cap_val[31:0], last_exp[0]);
    rd(4'd1, d); check32("R8 word1", d, last_exp[1]);
    check32("R7 both flags", {30'd0, cap_flag}, 32'd3);

    // R9 write-one-to-clear: only ch0
    w1c(2'b01);
    check32("R9 ch0 cleared, ch1 kept", {30'd0, cap_flag}, 32'd2);
    check32("R12 irq drops with flag", {31'd0, cap_irq[0]}, '0);
    w1c(2'b00);
    check32("R9 zero mask keeps ch1", {30'd0, cap_flag}, 32'd2);
    w1c(2'b10);
    check32("R9 ch1 cleared", {30'd0, cap_flag}, '0);

    // R5 both edges, R10 overwrite while flag set
    bmode[0] = 2'd3;
    drive_pin(0, 1'b1, "R5 rising in both mode");
    drive_pin(0, 1'b0, "R10 overwrite while flag set");
    drained("R5");
    check32("R10 flag stays set", {31'd0, cap_flag[0]}, 32'd1);

    // R6 ch1 code off must not follow ch0 code
    bmode[1] = 2'd0;
    drive_pin(1, 1'b1, "R6"); drive_pin(1, 1'b0, "R6");
    drained("R6 ch1 off");
    check32("R6 ch1 flag", {31'd0, cap_flag[1]}, '0);

    // R11 capture and clear at the same edge
    @(negedge clk);
    pin[0] = 1'b1;
    last_exp[0] = cnt + 32'd2;
    exp_q0.push_back(cnt + 32'd2); req_q0.push_back("R11 capture value");
    @(negedge clk); @(negedge clk);
    bus_addr = 4'd2; bus_wr = 1'b1; bus_wdata = 2'b01;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    check32("R11 capture beats clear", {31'd0, cap_flag[0]}, 32'd1);
    repeat (3) @(negedge clk);
    drained("R11");
    w1c(2'b01);
    check32("R9 clear alone", {31'd0, cap_flag[0]}, '0);

    repeat (4) @(negedge clk);
    drained("R7 end");
    finish_up();
  end

endmodule